// File: doc/BRIEF.md
# Compressed Rule Vector Expander

In a classifier that stores one bit per rule for every interval of a header field, most stored bits are zero. The table can instead hold short vectors per interval. Each interval entry then carries two fields: a region address, and a compressed vector whose width equals the largest number of rules that overlap any single interval of the field. The region address picks a list of rule numbers from an index table. Bit x of the compressed vector stands for the x-th rule number in that list. Rules that are wildcarded in this field are kept once, in a separate don't-care vector, instead of in every interval.

This block turns one such entry back into the full rule vector for its field. The output starts from the don't-care vector. Each set compressed bit then adds the rule that its list slot names. All slots are decoded in parallel, and the full vector is registered. The next stage ANDs it with the vectors of the other fields. A configuration port writes the index table and the don't-care vector.

Top module: `cbv_expander`

## Requirements
- R1: Reset clears `outValid`, `outVector`, the don't-care vector and every index-table slot. A cleared slot holds the null rule number 0.
- R2: A lookup accepted at a clock edge gives `outValid` = 1 and its `outVector` just after that same edge. That is a latency of one cycle. `outValid` is 0 in every cycle that has no accepted lookup.
- R3: `lookupEntry` is the region address in its upper `ADDR_W` bits and the compressed vector in its lower `MOP` bits. Compressed bit 1 is the most significant bit of the lower field and maps to list slot 0. Compressed bit x maps to slot x-1.
- R4: Rule numbers run from 1 to `NUM_RULES`. Rule n is bit `NUM_RULES-n` of every full vector, so rule 1 is the leftmost bit. The output is the don't-care vector ORed with the bit of rule list[x] for every set compressed bit x.
- R5: A slot holding 0, or a number above `NUM_RULES`, never sets an output bit, even when its compressed bit is 1. A compressed vector of all zeros gives the don't-care vector alone.
- R6: A lookup in the same cycle as any configuration write is not accepted. In that case `outValid` stays 0 and `outVector` keeps its previous value.
- R7: A write with `cfgListWe` stores `cfgRuleNum` into slot `cfgSlot` of region `cfgRegion`. A write with `cfgDcvWe` loads `cfgDcv`. Both take effect for lookups from the next cycle on. A write with `cfgSlot` >= `MOP` changes nothing.
- R8: With address 01, compressed 11101, list 1,2,5,6,8 and don't-care 000000000011, the output is 110010010011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgListWe | input | 1 | Write one index-table slot |
| cfgRegion | input | ADDR_W | Region of the slot written |
| cfgSlot | input | SLOT_W | Slot within the region's list |
| cfgRuleNum | input | RULE_W | Rule number stored (0 = null) |
| cfgDcvWe | input | 1 | Load the don't-care vector |
| cfgDcv | input | NUM_RULES | New don't-care vector |
| lookupValid | input | 1 | Lookup request |
| lookupEntry | input | ADDR_W+MOP | Region address and compressed vector |
| outValid | output | 1 | Expanded vector valid |
| outVector | output | NUM_RULES | Expanded rule vector, rule 1 leftmost |

## Verification
An accepted lookup shows up one clock later, on both `outValid` and `outVector`. The bench drives every request on a falling edge and reads the outputs at the next falling edge. This is half a cycle after the registering edge, so each result is read in the cycle it is due. Configuration writes also take effect at one edge. For that reason a lookup is only issued in the cycle after its write. The exception is the collision test, which drives both in the same cycle. It then checks that, one cycle later, `outValid` is still low and `outVector` still holds its earlier value.

// File: rtl/cbv_pkg.sv
package cbv_pkg;
  typedef struct packed {
    logic listWr;
    logic dcvWr;
    logic capture;
  } cbvStrobes_t;
endpackage

// File: rtl/cbv_ctrl.sv
module cbv_ctrl
  import cbv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgListWe,
  input  logic        cfgDcvWe,
  input  logic        lookupValid,
  output cbvStrobes_t strobes,
  output logic        outValid
);
  logic cfgBusy;

  always_comb begin
    cfgBusy         = cfgListWe | cfgDcvWe;
    strobes.listWr  = cfgListWe;
    strobes.dcvWr   = cfgDcvWe;
    strobes.capture = lookupValid & ~cfgBusy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= strobes.capture;
  end

  // R6: a lookup colliding with a configuration write is dropped
  a_r6_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && (cfgListWe || cfgDcvWe)) |=> !outValid);
  // R2: an uncontested lookup is answered one cycle later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && !cfgListWe && !cfgDcvWe) |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |=> !outValid);
endmodule

// File: rtl/cbv_datapath.sv
module cbv_datapath
  import cbv_pkg::*;
#(
  parameter int NUM_RULES = 12,
  parameter int MOP       = 5,
  parameter int REGIONS   = 4,
  localparam int ADDR_W   = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  localparam int SLOT_W   = (MOP > 1) ? $clog2(MOP) : 1,
  localparam int RULE_W   = $clog2(NUM_RULES + 1),
  localparam int ENTRY_W  = ADDR_W + MOP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cbvStrobes_t          strobes,
  input  logic [ADDR_W-1:0]    cfgRegion,
  input  logic [SLOT_W-1:0]    cfgSlot,
  input  logic [RULE_W-1:0]    cfgRuleNum,
  input  logic [NUM_RULES-1:0] cfgDcv,
  input  logic [ENTRY_W-1:0]   lookupEntry,
  output logic [NUM_RULES-1:0] outVector
);
  logic [RULE_W-1:0]    listTbl [REGIONS][MOP];
  logic [NUM_RULES-1:0] dcvReg;
  logic [ADDR_W-1:0]    lkRegion;
  logic [MOP-1:0]       lkCvec;
  logic                 lkRegionOk;
  logic [NUM_RULES-1:0] slotMask [MOP];
  logic [NUM_RULES-1:0] expanded;

  assign lkRegion   = lookupEntry[ENTRY_W-1 -: ADDR_W];
  assign lkCvec     = lookupEntry[MOP-1:0];
  assign lkRegionOk = 32'(lkRegion) < REGIONS;

  // index table and don't-care storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < REGIONS; r++)
        for (int s = 0; s < MOP; s++)
          listTbl[r][s] <= '0;
      dcvReg <= '0;
    end else begin
      if (strobes.listWr && (32'(cfgSlot) < MOP) && (32'(cfgRegion) < REGIONS))
        listTbl[cfgRegion][cfgSlot] <= cfgRuleNum;
      if (strobes.dcvWr)
        dcvReg <= cfgDcv;
    end
  end

  // one decoder per compressed bit; compressed bit 1 is the MSB -> slot 0
  for (genvar s = 0; s < MOP; s++) begin : g_slot
    logic              slotBit;
    logic [RULE_W-1:0] slotRule;
    assign slotBit  = lkCvec[MOP-1-s] & lkRegionOk;
    assign slotRule = lkRegionOk ? listTbl[lkRegion][s] : '0;
    always_comb begin
      for (int n = 1; n <= NUM_RULES; n++)
        slotMask[s][NUM_RULES-n] = slotBit && (32'(slotRule) == n);
    end
  end

  always_comb begin
    expanded = dcvReg;
    for (int s = 0; s < MOP; s++)
      expanded = expanded | slotMask[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               outVector <= '0;
    else if (strobes.capture) outVector <= expanded;
  end

  // R6: without an accepted lookup the output holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capture |=> $stable(outVector));
  // R4: every wildcarded rule appears in the result
  a_r4_dcv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |=> ((outVector & $past(dcvReg)) == $past(dcvReg)));
  // R5: an empty compressed vector yields the don't-care vector alone
  a_r5_empty_cvec: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && lkCvec == '0) |=> (outVector == $past(dcvReg)));
  // R4: each lookup adds at most MOP rules beyond the wildcards
  a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |=> ($countones(outVector & ~$past(dcvReg)) <= MOP));
endmodule

// File: rtl/cbv_expander.sv
module cbv_expander
  import cbv_pkg::*;
#(
  parameter int NUM_RULES = 12,
  parameter int MOP       = 5,
  parameter int REGIONS   = 4,
  localparam int ADDR_W   = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  localparam int SLOT_W   = (MOP > 1) ? $clog2(MOP) : 1,
  localparam int RULE_W   = $clog2(NUM_RULES + 1),
  localparam int ENTRY_W  = ADDR_W + MOP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgListWe,
  input  logic [ADDR_W-1:0]    cfgRegion,
  input  logic [SLOT_W-1:0]    cfgSlot,
  input  logic [RULE_W-1:0]    cfgRuleNum,
  input  logic                 cfgDcvWe,
  input  logic [NUM_RULES-1:0] cfgDcv,
  input  logic                 lookupValid,
  input  logic [ENTRY_W-1:0]   lookupEntry,
  output logic                 outValid,
  output logic [NUM_RULES-1:0] outVector
);
  cbvStrobes_t strobes;

  cbv_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgListWe  (cfgListWe),
    .cfgDcvWe   (cfgDcvWe),
    .lookupValid(lookupValid),
    .strobes    (strobes),
    .outValid   (outValid)
  );

  cbv_datapath #(
    .NUM_RULES(NUM_RULES),
    .MOP      (MOP),
    .REGIONS  (REGIONS)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .cfgRegion  (cfgRegion),
    .cfgSlot    (cfgSlot),
    .cfgRuleNum (cfgRuleNum),
    .cfgDcv     (cfgDcv),
    .lookupEntry(lookupEntry),
    .outVector  (outVector)
  );
endmodule

// File: tb/test_cbv_expander.sv
module test_cbv_expander;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 12;
  localparam int MOP = 5;
  localparam int REG = 4;
  localparam int AW  = 2;
  localparam int SW  = 3;
  localparam int RW  = 4;
  localparam int EW  = AW + MOP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfgListWe = 1'b0;
  logic [AW-1:0] cfgRegion = '0;
  logic [SW-1:0] cfgSlot = '0;
  logic [RW-1:0] cfgRuleNum = '0;
  logic          cfgDcvWe = 1'b0;
  logic [N-1:0]  cfgDcv = '0;
  logic          lookupValid = 1'b0;
  logic [EW-1:0] lookupEntry = '0;
  logic          outValid;
  logic [N-1:0]  outVector;

  int compared = 0;
  int mismatched = 0;
  logic [RW-1:0] shadowList [REG][MOP];
  logic [N-1:0]  shadowDcv;

  cbv_expander #(.NUM_RULES(N), .MOP(MOP), .REGIONS(REG)) i_cbv_expander (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // lookup table: {entry, expected full vector}; region lists set up below
  typedef struct packed { logic [EW-1:0] entry; logic [N-1:0] exp; } vec_t;
  localparam vec_t VECS [6] = '{
    '{7'b01_11101, 12'b110010010011},  // R8 worked example
    '{7'b00_10100, 12'b100100000011},  // R4
    '{7'b00_11111, 12'b101100000011},  // R5 padded null slots
    '{7'b10_01011, 12'b000000100111},  // R3 slot order
    '{7'b11_11110, 12'b010100000011},  // R5 out-of-range rule number
    '{7'b10_00000, 12'b000000000011}   // R5 empty compressed vector
  };

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic writeSlot(int r, int s, int num);
    @(negedge clk);
    cfgListWe = 1'b1; cfgRegion = AW'(r); cfgSlot = SW'(s); cfgRuleNum = RW'(num);
    if (s < MOP) shadowList[r][s] = RW'(num);
    @(negedge clk);
    cfgListWe = 1'b0;
  endtask

  task automatic writeDcv(logic [N-1:0] v);
    @(negedge clk);
    cfgDcvWe = 1'b1; cfgDcv = v; shadowDcv = v;
    @(negedge clk);
    cfgDcvWe = 1'b0;
  endtask

  // drive at a falling edge, registered at the next rising edge, read at the falling edge after
  task automatic lookup(logic [EW-1:0] e);
    @(negedge clk);
    lookupValid = 1'b1; lookupEntry = e;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  function automatic logic [N-1:0] model(logic [EW-1:0] e);
    logic [N-1:0] v = shadowDcv;
    int r = int'(e[EW-1 -: AW]);
    for (int x = 0; x < MOP; x++) begin
      int num = int'(shadowList[r][x]);
      if (e[MOP-1-x] && num >= 1 && num <= N) v[N-num] = 1'b1;
    end
    return v;
  endfunction

  initial begin
    for (int r = 0; r < REG; r++) for (int s = 0; s < MOP; s++) shadowList[r][s] = '0;
    shadowDcv = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", N'(outValid), N'(0));
    check("R1 outVector", outVector, '0);
    rst_n = 1'b1;
    // R1: cleared table and dcv give an all-zero vector
    lookup(7'b01_11111);
    check("R1 cleared table", outVector, '0);

    begin
      int lists [REG][MOP] = '{'{1,3,4,0,0}, '{1,2,5,6,8}, '{3,7,9,10,0}, '{2,4,12,15,0}};
      for (int r = 0; r < REG; r++) for (int s = 0; s < MOP; s++) writeSlot(r, s, lists[r][s]);
    end
    writeDcv(12'b000000000011);

    for (int i = 0; i < 6; i++) begin
      lookup(VECS[i].entry);
      check("R2 outValid", N'(outValid), N'(1));
      check("R4 table vector", outVector, VECS[i].exp);
    end

    // R2: valid drops when no lookup
    @(negedge clk);
    check("R2 idle outValid", N'(outValid), N'(0));

    // R7: dcv rewrite visible on the next lookup
    writeDcv('0);
    lookup(7'b01_11101);
    check("R7 dcv rewrite", outVector, 12'b110010010000);

    // R6: collision with a write is dropped
    @(negedge clk);
    lookupValid = 1'b1; lookupEntry = 7'b00_11111; cfgListWe = 1'b1;
    cfgRegion = 2'd3; cfgSlot = 3'd4; cfgRuleNum = 4'd6; shadowList[3][4] = 4'd6;
    @(negedge clk);
    lookupValid = 1'b0; cfgListWe = 1'b0;
    check("R6 blocked outValid", N'(outValid), N'(0));
    check("R6 blocked vector held", outVector, 12'b110010010000);
    // R7: the slot written during the collision is used afterwards
    lookup(7'b11_00001);
    check("R7 written slot", outVector, 12'b000001000000);

    // R7: slot index beyond MOP changes nothing
    writeSlot(0, 6, 9);
    lookup(7'b00_11111);
    check("R7 out-of-range slot", outVector, 12'b101100000000);

    // random rule sets against the uncompressed model
    for (int k = 0; k < 40; k++) begin
      for (int r = 0; r < REG; r++)
        for (int s = 0; s < MOP; s++) writeSlot(r, s, $urandom_range(0, 15));
      writeDcv(N'($urandom));
      for (int j = 0; j < 8; j++) begin
        logic [EW-1:0] e = EW'($urandom);
        lookup(e);
        check("R4 random", outVector, model(e));
      end
    end

    // R1: reset in mid-run clears the output
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset vector", outVector, '0);
    check("R1 re-reset valid", N'(outValid), N'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule